// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the programmed state of a single DMA channel and steps it through a transfer sequence. Software loads a source address, a destination address, a unit count and a control word through a simple write port. The channel is active when it is enabled and its end flag is clear. While active it asks for the bus. Each time the transfer is allowed, it presents a read address, a write address and a unit size, then moves both addresses and lowers the count by one.

A grant input takes the place of the arbiter. In cycle-steal mode every unit needs its own grant. In burst mode the first grant captures the bus, and units then run on every cycle until the count runs out. When the count reaches zero the channel raises an end flag, and an interrupt if that is enabled. One channel instance, chosen by parameter, can restore its starting source address when a run ends.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the address registers, count and control word read zero, and `req_o`, `hold_o`, `done_o` and `irq_o` are low.
- R2: A write with `wr_sel` 0 loads the source address, 1 loads the destination address, 2 loads the count (only `wr_data[23:0]` is kept), and 3 loads the control word. The control bits are: 0 enable, 1 end flag, 2 interrupt enable, 4:3 size code, 5 burst, 13:12 source mode, 15:14 destination mode, 19 source reload. All other control bits read zero.
- R3: `req_o` is high exactly when enable is 1 and the end flag is 0. While `req_o` is low, `grant_i` changes neither the addresses nor the count.
- R4: A unit transfer happens on a clock edge where `req_o` is high and either `grant_i` or `hold_o` is high. During that cycle `rd_addr_o` is the source address and `wr_addr_o` is the destination address. After that edge the count is one lower.
- R5: `size_o` gives the unit size in bytes for size code 0/1/2/3: 1, 2, 4 or 16.
- R6: Address mode 0 keeps the address fixed, 1 adds the unit size, and 2 subtracts it, all modulo 2^32. Mode 3 behaves as fixed. The source and destination use their own modes.
- R7: A programmed count of 0 stands for 2^24 units. The first transfer leaves 0xFFFFFF, and the end flag stays clear.
- R8: The transfer that brings the count from 1 to 0 sets the end flag (`done_o`, control bit 1). `irq_o` is high while the end flag and interrupt enable are both 1.
- R9: Writing 0 to control bit 1 clears the end flag. Writing 1 there leaves the flag unchanged.
- R10: In burst mode one grant starts the run. `hold_o` is then high and a unit moves on every cycle without a grant, until the final unit drops `hold_o`. In cycle-steal mode `hold_o` stays low.
- R11: On the reload-capable instance (the default), with control bit 19 set, the final transfer puts back the source address last written through the port instead of stepping it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| wr_data | input | 32 | Write data |
| grant_i | input | 1 | Bus grant standing in for the arbiter |
| req_o | output | 1 | Channel requests a transfer |
| hold_o | output | 1 | Burst in progress, bus kept |
| rd_addr_o | output | 32 | Current source (read) address |
| wr_addr_o | output | 32 | Current destination (write) address |
| size_o | output | 5 | Unit size in bytes |
| count_o | output | 24 | Remaining unit count |
| ctrl_o | output | 32 | Stored control word |
| done_o | output | 1 | End flag |
| irq_o | output | 1 | End-of-transfer interrupt |

## Verification
The embedded assertions check several rules on every cycle. No unit moves while the request is low. A counted transfer lowers the count by exactly one. A fixed-mode address does not move. The end flag rises only on the final unit. A flag write of 1 never clears it. `hold_o` is only ever high in burst mode. The bench scenarios cover what needs exact values: the stepped addresses for each size and mode pair, wraparound, the 2^24 meaning of a zero count, the reload result, and the cycle-by-cycle progress of a burst that runs without further grants.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    AMODE_FIXED = 2'd0,
    AMODE_UP    = 2'd1,
    AMODE_DOWN  = 2'd2,
    AMODE_RSVD  = 2'd3
  } amode_e;

  localparam int CB_EN    = 0;
  localparam int CB_END   = 1;
  localparam int CB_IE    = 2;
  localparam int CB_TS_LO = 3;
  localparam int CB_BURST = 5;
  localparam int CB_SM_LO = 12;
  localparam int CB_DM_LO = 14;
  localparam int CB_RLD   = 19;

  // unit size in bytes from the 2-bit size code
  function automatic logic [4:0] unit_bytes(input logic [1:0] code);
    logic [4:0] b;
    case (code)
      2'd0:    b = 5'd1;
      2'd1:    b = 5'd2;
      2'd2:    b = 5'd4;
      default: b = 5'd16;
    endcase
    return b;
  endfunction

  // next address after one unit for a given mode
  function automatic logic [31:0] step_addr(input logic [31:0] a,
                                            input amode_e m,
                                            input logic [4:0] bytes);
    logic [31:0] r;
    case (m)
      AMODE_UP:   r = a + {27'd0, bytes};
      AMODE_DOWN: r = a - {27'd0, bytes};
      default:    r = a;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
  import dma_chan_pkg::*;
#(
  parameter int  REG_W     = 32,
  parameter bit  RELOAD_OK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic [REG_W-1:0] wdata,
  input  logic             end_evt,
  output logic [REG_W-1:0] ctrl_q,
  output logic             en,
  output logic             te,
  output logic             ie,
  output logic             burst,
  output logic [1:0]       ts,
  output amode_e           smode,
  output amode_e           dmode,
  output logic             rld
);

  localparam logic [REG_W-1:0] BASE_MASK = REG_W'(32'h0000_F03D);
  localparam logic [REG_W-1:0] RLD_MASK  = REG_W'(32'h0008_0000);
  localparam logic [REG_W-1:0] WR_MASK   = RELOAD_OK ? (BASE_MASK | RLD_MASK) : BASE_MASK;

  logic te_next;
  logic te_q;
  logic [REG_W-1:0] fields_q;

  // flag: hardware set wins, software can only clear
  always_comb begin
    te_next = te_q;
    if (wr_ctrl) te_next = te_q & wdata[CB_END];
    if (end_evt) te_next = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '0;
      te_q     <= 1'b0;
    end else begin
      te_q <= te_next;
      if (wr_ctrl) fields_q <= wdata & WR_MASK;
    end
  end

  always_comb begin
    ctrl_q         = fields_q;
    ctrl_q[CB_END] = te_q;
  end

  assign en    = fields_q[CB_EN];
  assign te    = te_q;
  assign ie    = fields_q[CB_IE];
  assign burst = fields_q[CB_BURST];
  assign ts    = fields_q[CB_TS_LO +: 2];
  assign smode = amode_e'(fields_q[CB_SM_LO +: 2]);
  assign dmode = amode_e'(fields_q[CB_DM_LO +: 2]);
  assign rld   = fields_q[CB_RLD];

  // a write of 1 to the flag never clears it
  assert_flag_w1_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[CB_END] && te_q) |=> te_q);

endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter bit HAS_RELOAD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              step_evt,
  input  amode_e            mode,
  input  logic [4:0]        bytes,
  input  logic              reload_evt,
  output logic [ADDR_W-1:0] addr_q
);

  logic [ADDR_W-1:0] shadow;
  logic [ADDR_W-1:0] stepped;
  logic              do_reload;

  assign stepped   = ADDR_W'(step_addr(32'(addr_q), mode, bytes));
  assign do_reload = HAS_RELOAD && reload_evt;

  generate
    if (HAS_RELOAD) begin : g_shadow
      logic [ADDR_W-1:0] shadow_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  shadow_q <= '0;
        else if (wr) shadow_q <= wdata;
      end
      assign shadow = shadow_q;
    end else begin : g_no_shadow
      assign shadow = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          addr_q <= '0;
    else if (wr)         addr_q <= wdata;
    else if (do_reload)  addr_q <= shadow;
    else if (step_evt)   addr_q <= stepped;
  end

  // fixed and reserved modes never move the address
  assert_fixed_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !wr && !do_reload && (mode == AMODE_FIXED || mode == AMODE_RSVD))
      |=> $stable(addr_q));

endmodule

// File: rtl/dma_count_reg.sv
module dma_count_reg #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             dec_evt,
  output logic [CNT_W-1:0] count_q,
  output logic             last
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // zero wraps to all-ones, so a zero load means 2^CNT_W units
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (wr)      count_q <= wdata;
    else if (dec_evt) count_q <= count_q - ONE;
  end

  assign last = (count_q == ONE);

  assert_count_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_evt && !wr) |=> (count_q == $past(count_q) - ONE));

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 24,
  parameter int CHAN_ID     = 2,
  parameter int RELOAD_CHAN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              grant_i,
  output logic              req_o,
  output logic              hold_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [4:0]        size_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [31:0]       ctrl_o,
  output logic              done_o,
  output logic              irq_o
);

  localparam bit RELOAD_OK = (CHAN_ID == RELOAD_CHAN);

  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  logic   wr_src, wr_dst, wr_cnt, wr_ctl;
  logic   en, te, ie, burst, rld, last;
  logic [1:0] ts;
  amode_e smode, dmode;
  logic   fire, end_evt, hold_q;
  logic [4:0] bytes;

  assign wr_src = wr_en && (wr_sel == SEL_SRC);
  assign wr_dst = wr_en && (wr_sel == SEL_DST);
  assign wr_cnt = wr_en && (wr_sel == SEL_CNT);
  assign wr_ctl = wr_en && (wr_sel == SEL_CTL);

  assign bytes   = unit_bytes(ts);
  assign req_o   = en && !te;
  assign fire    = req_o && (grant_i || hold_q);
  assign end_evt = fire && last;

  dma_ctrl_reg #(.REG_W(32), .RELOAD_OK(RELOAD_OK)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctl), .wdata(wr_data),
    .end_evt(end_evt), .ctrl_q(ctrl_o), .en(en), .te(te), .ie(ie),
    .burst(burst), .ts(ts), .smode(smode), .dmode(dmode), .rld(rld)
  );

  dma_addr_reg #(.ADDR_W(ADDR_W), .HAS_RELOAD(RELOAD_OK)) u_src (
    .clk(clk), .rst_n(rst_n), .wr(wr_src), .wdata(wr_data[ADDR_W-1:0]),
    .step_evt(fire), .mode(smode), .bytes(bytes),
    .reload_evt(end_evt && rld), .addr_q(rd_addr_o)
  );

  dma_addr_reg #(.ADDR_W(ADDR_W), .HAS_RELOAD(1'b0)) u_dst (
    .clk(clk), .rst_n(rst_n), .wr(wr_dst), .wdata(wr_data[ADDR_W-1:0]),
    .step_evt(fire), .mode(dmode), .bytes(bytes),
    .reload_evt(1'b0), .addr_q(wr_addr_o)
  );

  dma_count_reg #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr(wr_cnt), .wdata(wr_data[CNT_W-1:0]),
    .dec_evt(fire), .count_q(count_o), .last(last)
  );

  // burst keeps the bus from the first granted unit to the last one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold_q <= 1'b0;
    else if (!req_o || !burst) hold_q <= 1'b0;
    else if (fire)             hold_q <= !last;
  end

  assign hold_o = hold_q;
  assign size_o = bytes;
  assign done_o = te;
  assign irq_o  = te && ie;

  assert_no_unit_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_o && !wr_cnt) |=> $stable(count_o));

  assert_hold_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> burst);

  assert_end_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(fire && last));

  assert_irq_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (done_o && ctrl_o[CB_IE]));

endmodule

// File: tb/dma_chan_engine_tb_top.sv
module dma_chan_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = 32'd0;
  logic        grant_i = 1'b0;
  logic        req_o, hold_o, done_o, irq_o;
  logic [31:0] rd_addr_o, wr_addr_o, ctrl_o;
  logic [4:0]  size_o;
  logic [23:0] count_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .grant_i(grant_i), .req_o(req_o), .hold_o(hold_o), .rd_addr_o(rd_addr_o),
    .wr_addr_o(wr_addr_o), .size_o(size_o), .count_o(count_o), .ctrl_o(ctrl_o),
    .done_o(done_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [1:0]  sm;
    logic [1:0]  dm;
    logic [1:0]  ts;
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] exp_src;
    logic [31:0] exp_dst;
    logic [4:0]  exp_size;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 2'd1, 2'd0, 32'h100, 32'h200, 32'h101, 32'h201, 5'd1},
    '{2'd2, 2'd0, 2'd1, 32'h100, 32'h200, 32'h0FE, 32'h200, 5'd2},
    '{2'd0, 2'd2, 2'd2, 32'h100, 32'h200, 32'h100, 32'h1FC, 5'd4},
    '{2'd1, 2'd2, 2'd3, 32'h100, 32'h200, 32'h110, 32'h1F0, 5'd16},
    '{2'd2, 2'd1, 2'd3, 32'h0, 32'hFFFF_FFF8, 32'hFFFF_FFF0, 32'h8, 5'd16},
    '{2'd3, 2'd3, 2'd2, 32'h100, 32'h200, 32'h100, 32'h200, 5'd4}
  };

  function automatic logic [31:0] ctl_word(input logic [1:0] sm, input logic [1:0] dm,
                                           input logic [1:0] ts, input bit burst,
                                           input bit ie, input bit rld, input bit flag);
    return 32'd1 | (32'(flag) << 1) | (32'(ie) << 2) | (32'(ts) << 3) | (32'(burst) << 5)
         | (32'(sm) << 12) | (32'(dm) << 14) | (32'(rld) << 19);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic grant_once();
    @(negedge clk);
    grant_i = 1'b1;
    @(negedge clk);
    grant_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WD_LIMIT; c++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected <%0d cycles", WD_LIMIT, WD_LIMIT);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rd_addr_o == 0 && wr_addr_o == 0, "R1 addresses", rd_addr_o, 0);
    check(count_o == 0 && ctrl_o == 0, "R1 count/ctrl", {8'd0, count_o}, 0);
    check({req_o, hold_o, done_o, irq_o} == 4'b0, "R1 outputs",
          {28'd0, req_o, hold_o, done_o, irq_o}, 0);
    rst_n = 1'b1;

    // R2 control field storage, unused bits drop
    wr_reg(2'd3, 32'hFFFF_FFFC);
    check(ctrl_o == 32'h0008_F03C, "R2 ctrl mask", ctrl_o, 32'h0008_F03C);
    check(!req_o, "R3 req low when disabled", {31'd0, req_o}, 0);
    wr_reg(2'd2, 32'hAB12_3456);
    check(count_o == 24'h123456, "R2 count low 24 bits", {8'd0, count_o}, 32'h123456);
    grant_once();
    check(count_o == 24'h123456, "R3 grant ignored when disabled", {8'd0, count_o}, 32'h123456);

    // R4/R5/R6 table of single-unit steps
    for (int i = 0; i < NVEC; i++) begin
      wr_reg(2'd0, VECS[i].src);
      wr_reg(2'd1, VECS[i].dst);
      wr_reg(2'd2, 32'd5);
      wr_reg(2'd3, ctl_word(VECS[i].sm, VECS[i].dm, VECS[i].ts, 0, 0, 0, 0));
      check(req_o, "R3 req high when enabled", {31'd0, req_o}, 1);
      check(size_o == VECS[i].exp_size, "R5 unit size", {27'd0, size_o}, {27'd0, VECS[i].exp_size});
      check(rd_addr_o == VECS[i].src && wr_addr_o == VECS[i].dst, "R4 presented addresses",
            rd_addr_o, VECS[i].src);
      grant_once();
      check(rd_addr_o == VECS[i].exp_src, "R6 source step", rd_addr_o, VECS[i].exp_src);
      check(wr_addr_o == VECS[i].exp_dst, "R6 destination step", wr_addr_o, VECS[i].exp_dst);
      check(count_o == 24'd4, "R4 count decrement", {8'd0, count_o}, 4);
      check(!hold_o, "R10 no hold in cycle-steal", {31'd0, hold_o}, 0);
    end

    // R7 zero count is 2^24
    wr_reg(2'd2, 32'd0);
    grant_once();
    check(count_o == 24'hFFFFFF && !done_o, "R7 zero count", {8'd0, count_o}, 32'hFFFFFF);

    // R8/R9 end flag, interrupt and clearing
    wr_reg(2'd0, 32'h40);
    wr_reg(2'd2, 32'd1);
    wr_reg(2'd3, ctl_word(2'd1, 2'd1, 2'd0, 0, 1, 0, 0));
    check(!irq_o && !done_o, "R8 no flag before last unit", {31'd0, done_o}, 0);
    grant_once();
    check(done_o && count_o == 0, "R8 flag on last unit", {31'd0, done_o}, 1);
    check(irq_o, "R8 interrupt", {31'd0, irq_o}, 1);
    check(!req_o, "R3 req drops on flag", {31'd0, req_o}, 0);
    grant_once();
    check(rd_addr_o == 32'h41 && count_o == 0, "R3 grant ignored after end", rd_addr_o, 32'h41);
    wr_reg(2'd3, ctl_word(2'd1, 2'd1, 2'd0, 0, 1, 0, 1));
    check(done_o && irq_o, "R9 write 1 keeps flag", {31'd0, done_o}, 1);
    wr_reg(2'd3, ctl_word(2'd1, 2'd1, 2'd0, 0, 1, 0, 0));
    check(!done_o && !irq_o, "R9 write 0 clears flag", {31'd0, done_o}, 0);
    wr_reg(2'd3, 32'd0);

    // R10 burst: one grant, then units every cycle
    wr_reg(2'd1, 32'h800);
    wr_reg(2'd2, 32'd3);
    wr_reg(2'd3, ctl_word(2'd0, 2'd1, 2'd0, 1, 0, 0, 0));
    grant_once();
    check(hold_o && count_o == 24'd2, "R10 burst start", {8'd0, count_o}, 2);
    @(negedge clk);
    check(hold_o && count_o == 24'd1 && wr_addr_o == 32'h802, "R10 burst runs without grant",
          {8'd0, count_o}, 1);
    @(negedge clk);
    check(!hold_o && done_o && wr_addr_o == 32'h803, "R10 burst end", wr_addr_o, 32'h803);
    wr_reg(2'd3, 32'd0);

    // R11 source reload on the final unit
    wr_reg(2'd0, 32'h1000);
    wr_reg(2'd2, 32'd2);
    wr_reg(2'd3, ctl_word(2'd1, 2'd0, 2'd2, 0, 0, 1, 0));
    grant_once();
    check(rd_addr_o == 32'h1004, "R11 step before end", rd_addr_o, 32'h1004);
    grant_once();
    check(rd_addr_o == 32'h1000 && done_o, "R11 reload at end", rd_addr_o, 32'h1000);

    finish_run();
  end

endmodule